// File: doc/BRIEF.md
# Per-Load Stride Prefetch Predictor

The block watches the stream of executed loads and learns, for each load instruction, whether it walks memory with a constant step. A direct-mapped table indexed by the load's program counter keeps a tag, the last address that load touched, a candidate step and a two-bit confidence state per entry. When a load's entry is confident in a non-zero step, the block emits a prefetch address one step ahead of the address just used.

Each load is presented as a one-cycle strobe with its PC and effective address. The table entry is read and rewritten in the cycle after the strobe, and the prefetch request comes out of a register one cycle later. A prefetch is a single-cycle pulse with no handshake; any buffering or throttling belongs to the consumer.

Top module: `stride_pf_top`

## Requirements
- R1: After reset `pf_valid_o` is 0 and every table entry is empty, so the first load from any PC is treated as a miss.
- R2: The entry index is `ld_pc_i[ALIGN_BITS+IDX_W-1:ALIGN_BITS]` (IDX_W = log2 ENTRIES) and the tag is the PC bits above it; a load whose entry is empty or holds another tag takes the entry over with its own tag and address, a step of 0 and state INIT, and produces no prefetch.
- R3: A prediction is correct when the load address equals the stored previous address plus the stored step (modulo 2^ADDR_W). From INIT a correct load moves to STEADY; an incorrect one moves to TRANSIENT and the step becomes current minus previous address.
- R4: From STEADY a correct load stays in STEADY; an incorrect one returns to INIT and keeps the old step.
- R5: From TRANSIENT a correct load moves to STEADY; an incorrect one moves to NO-PREDICTION and replaces the step.
- R6: From NO-PREDICTION a correct load moves to TRANSIENT (no prefetch); an incorrect one stays and replaces the step.
- R7: A prefetch is issued only when the entry's new state is STEADY and its step is non-zero; its address is the load address plus the step modulo 2^ADDR_W, so negative steps and wrap-around work.
- R8: A load strobed before clock edge N yields `pf_valid_o` high between edges N+1 and N+2 only; loads on consecutive cycles to the same entry each see the update made by the one before.
- R9: The previous address of a hit entry is overwritten with the current address on every access, and entries at different indices train independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | A load executes this cycle |
| ld_pc_i | input | PC_W | Program counter of the load |
| ld_addr_i | input | ADDR_W | Effective address of the load |
| pf_valid_o | output | 1 | Prefetch request valid, one-cycle pulse |
| pf_addr_o | output | ADDR_W | Prefetch address |

## Verification
The bench walks one entry through every state edge, including the NO-PREDICTION loop where a design that confused the step-replacement rule would predict the wrong next address, and a STEADY break where a design that overwrote the step would fail to recover after one load. A repeated address must not prefetch, since a design ignoring the non-zero-step rule would request the line already in use. Two PCs sharing an index must evict each other without prefetching, and two PCs at different indices must train side by side. Back-to-back loads check that the second read sees the first write, while a negative step and an address near the top of the range catch sign and wrap mistakes in the adder.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  typedef enum logic [1:0] {
    ST_INIT   = 2'b00,
    ST_TRANS  = 2'b01,
    ST_STEADY = 2'b10,
    ST_NOPRED = 2'b11
  } conf_e;
endpackage

// File: rtl/stride_pf_table.sv
module stride_pf_table
  import stride_pf_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 24,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [ADDR_W-1:0] rd_prev_o,
  output logic [ADDR_W-1:0] rd_stride_o,
  output conf_e             rd_state_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_prev_i,
  input  logic [ADDR_W-1:0] wr_stride_i,
  input  conf_e             wr_state_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  prev_q   [ENTRIES];
  logic [ADDR_W-1:0]  stride_q [ENTRIES];
  conf_e              state_q  [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  // payload needs no reset: guarded by valid_q
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]    <= wr_tag_i;
      prev_q[wr_idx_i]   <= wr_prev_i;
      stride_q[wr_idx_i] <= wr_stride_i;
      state_q[wr_idx_i]  <= wr_state_i;
    end
  end

  assign rd_valid_o  = valid_q[rd_idx_i];
  assign rd_tag_o    = tag_q[rd_idx_i];
  assign rd_prev_o   = prev_q[rd_idx_i];
  assign rd_stride_o = stride_q[rd_idx_i];
  assign rd_state_o  = state_q[rd_idx_i];
endmodule

// File: rtl/stride_pf_update.sv
module stride_pf_update
  import stride_pf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              hit_i,
  input  conf_e             state_i,
  input  logic [ADDR_W-1:0] prev_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [ADDR_W-1:0] addr_i,
  output conf_e             state_o,
  output logic [ADDR_W-1:0] stride_o,
  output logic              pf_v_o,
  output logic [ADDR_W-1:0] pf_addr_o
);
  logic [ADDR_W-1:0] predicted;
  logic [ADDR_W-1:0] observed;
  logic              correct;

  always_comb begin
    predicted = prev_i + stride_i;
    observed  = addr_i - prev_i;
    correct   = (addr_i == predicted);
    state_o   = ST_INIT;
    stride_o  = '0;
    if (hit_i) begin
      stride_o = stride_i;
      unique case (state_i)
        ST_INIT: begin
          if (correct) state_o = ST_STEADY;
          else begin
            state_o  = ST_TRANS;
            stride_o = observed;
          end
        end
        ST_STEADY: state_o = correct ? ST_STEADY : ST_INIT;
        ST_TRANS: begin
          if (correct) state_o = ST_STEADY;
          else begin
            state_o  = ST_NOPRED;
            stride_o = observed;
          end
        end
        ST_NOPRED: begin
          if (correct) state_o = ST_TRANS;
          else begin
            state_o  = ST_NOPRED;
            stride_o = observed;
          end
        end
        default: state_o = ST_INIT;
      endcase
    end
    pf_v_o    = hit_i && (state_o == ST_STEADY) && (stride_o != '0);
    pf_addr_o = addr_i + stride_o;
  end
endmodule

// File: rtl/stride_pf_top.sv
module stride_pf_top
  import stride_pf_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [PC_W-1:0]   ld_pc_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - ALIGN_BITS - IDX_W;

  logic              s_valid_q;
  logic [IDX_W-1:0]  s_idx_q;
  logic [TAG_W-1:0]  s_tag_q;
  logic [ADDR_W-1:0] s_addr_q;

  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_prev, rd_stride, nx_stride, nx_pf_addr;
  conf_e             rd_state, nx_state;
  logic              hit, nx_pf_v;

  logic unused_align;
  assign unused_align = ^ld_pc_i[ALIGN_BITS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_valid_q <= 1'b0;
    else         s_valid_q <= ld_valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_valid_i) begin
      s_idx_q  <= ld_pc_i[ALIGN_BITS +: IDX_W];
      s_tag_q  <= ld_pc_i[PC_W-1 -: TAG_W];
      s_addr_q <= ld_addr_i;
    end
  end

  stride_pf_table #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (s_idx_q),
    .rd_valid_o (rd_valid),
    .rd_tag_o   (rd_tag),
    .rd_prev_o  (rd_prev),
    .rd_stride_o(rd_stride),
    .rd_state_o (rd_state),
    .wr_en_i    (s_valid_q),
    .wr_idx_i   (s_idx_q),
    .wr_tag_i   (s_tag_q),
    .wr_prev_i  (s_addr_q),
    .wr_stride_i(nx_stride),
    .wr_state_i (nx_state)
  );

  assign hit = rd_valid && (rd_tag == s_tag_q);

  stride_pf_update #(.ADDR_W(ADDR_W)) u_update (
    .hit_i    (hit),
    .state_i  (rd_state),
    .prev_i   (rd_prev),
    .stride_i (rd_stride),
    .addr_i   (s_addr_q),
    .state_o  (nx_state),
    .stride_o (nx_stride),
    .pf_v_o   (nx_pf_v),
    .pf_addr_o(nx_pf_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_valid_o <= 1'b0;
      pf_addr_o  <= '0;
    end else begin
      pf_valid_o <= s_valid_q && nx_pf_v;
      if (s_valid_q && nx_pf_v) pf_addr_o <= nx_pf_addr;
    end
  end
endmodule

// File: rtl/stride_pf_chk.sv
module stride_pf_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_valid_i,
  input logic [ADDR_W-1:0] ld_addr_i,
  input logic              pf_valid_o,
  input logic [ADDR_W-1:0] pf_addr_o,
  input logic              s_valid_q,
  input logic              hit
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!pf_valid_o)
        else $error("pf_valid_o high during reset");
    end
  end

  p_miss_no_pf_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_q && !hit) |=> !pf_valid_o);

  p_pf_nonzero_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> (pf_addr_o != $past(ld_addr_i, 2)));

  p_pf_needs_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> $past(ld_valid_i, 2));

  p_pf_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_i |=> ##1 !pf_valid_o);
endmodule

bind stride_pf_top stride_pf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ld_valid_i(ld_valid_i),
  .ld_addr_i (ld_addr_i),
  .pf_valid_o(pf_valid_o),
  .pf_addr_o (pf_addr_o),
  .s_valid_q (s_valid_q),
  .hit       (hit)
);

// File: tb/stride_pf_top_tb_top.sv
`timescale 1ns/1ps
module stride_pf_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_valid_i = 1'b0;
  logic [31:0] ld_pc_i = '0;
  logic [31:0] ld_addr_i = '0;
  logic        pf_valid_o;
  logic [31:0] pf_addr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  stride_pf_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_valid_i(ld_valid_i),
    .ld_pc_i(ld_pc_i), .ld_addr_i(ld_addr_i),
    .pf_valid_o(pf_valid_o), .pf_addr_o(pf_addr_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one isolated load; sample after the registered output updates
  task automatic do_load(string req, logic [31:0] pc, logic [31:0] addr,
                         logic exp_v, logic [31:0] exp_a);
    @(negedge clk_i);
    ld_valid_i = 1'b1; ld_pc_i = pc; ld_addr_i = addr;
    @(negedge clk_i);
    ld_valid_i = 1'b0;
    @(posedge clk_i); #1;
    check({req, " pf_valid"}, {31'd0, pf_valid_o}, {31'd0, exp_v});
    if (exp_v) check({req, " pf_addr"}, pf_addr_o, exp_a);
  endtask

  task automatic t_reset();
    check("R1 reset pf_valid", {31'd0, pf_valid_o}, 32'd0);
    check("R1 reset pf_addr", pf_addr_o, 32'd0);
    do_load("R1 first load misses", 32'h0000_2000, 32'h100, 1'b0, 32'h0);
    do_load("R1 same value trains zero step", 32'h0000_2000, 32'h100, 1'b0, 32'h0);
  endtask

  task automatic t_train();
    do_load("R2 alloc", 32'h2010, 32'd100, 1'b0, 0);
    do_load("R3 init wrong", 32'h2010, 32'd104, 1'b0, 0);
    do_load("R5 trans correct", 32'h2010, 32'd108, 1'b1, 32'd112);
    do_load("R4 steady correct", 32'h2010, 32'd112, 1'b1, 32'd116);
  endtask

  task automatic t_zero_step();
    do_load("R2 alloc zero", 32'h2020, 32'h500, 1'b0, 0);
    do_load("R7 zero step no pf", 32'h2020, 32'h500, 1'b0, 0);
    do_load("R7 zero step steady no pf", 32'h2020, 32'h500, 1'b0, 0);
  endtask

  task automatic t_steady_break();
    do_load("R2 alloc brk", 32'h2030, 32'd100, 1'b0, 0);
    do_load("R3 brk init", 32'h2030, 32'd104, 1'b0, 0);
    do_load("R5 brk trans", 32'h2030, 32'd108, 1'b1, 32'd112);
    do_load("R4 steady wrong to init", 32'h2030, 32'd200, 1'b0, 0);
    do_load("R4 step kept, R3 init correct", 32'h2030, 32'd204, 1'b1, 32'd208);
  endtask

  task automatic t_nopred();
    do_load("R2 alloc np", 32'h2040, 32'd0, 1'b0, 0);
    do_load("R3 np init wrong", 32'h2040, 32'd10, 1'b0, 0);
    do_load("R5 trans wrong", 32'h2040, 32'd15, 1'b0, 0);
    do_load("R6 nopred wrong", 32'h2040, 32'd30, 1'b0, 0);
    do_load("R6 nopred correct", 32'h2040, 32'd45, 1'b0, 0);
    do_load("R6 back to trans then steady", 32'h2040, 32'd60, 1'b1, 32'd75);
  endtask

  task automatic t_negative();
    do_load("R2 alloc neg", 32'h2050, 32'd1000, 1'b0, 0);
    do_load("R7 neg init", 32'h2050, 32'd992, 1'b0, 0);
    do_load("R7 negative step", 32'h2050, 32'd984, 1'b1, 32'd976);
  endtask

  task automatic t_wrap();
    do_load("R2 alloc wrap", 32'h2090, 32'hFFFF_FFF0, 1'b0, 0);
    do_load("R7 wrap init", 32'h2090, 32'hFFFF_FFF4, 1'b0, 0);
    do_load("R7 wrap steady", 32'h2090, 32'hFFFF_FFF8, 1'b1, 32'hFFFF_FFFC);
    do_load("R7 wrap around", 32'h2090, 32'hFFFF_FFFC, 1'b1, 32'h0);
  endtask

  task automatic t_conflict();
    do_load("R2 alloc c", 32'h2060, 32'd0, 1'b0, 0);
    do_load("R2 c init", 32'h2060, 32'd8, 1'b0, 0);
    do_load("R2 c steady", 32'h2060, 32'd16, 1'b1, 32'd24);
    do_load("R2 other tag evicts", 32'h2160, 32'd24, 1'b0, 0);
    do_load("R2 original tag misses", 32'h2060, 32'd24, 1'b0, 0);
    do_load("R2 retrain from zero", 32'h2060, 32'd32, 1'b0, 0);
  endtask

  task automatic t_interleave();
    do_load("R9 a alloc", 32'h2070, 32'h1000, 1'b0, 0);
    do_load("R9 b alloc", 32'h2074, 32'h8000, 1'b0, 0);
    do_load("R9 a init", 32'h2070, 32'h1040, 1'b0, 0);
    do_load("R9 b init", 32'h2074, 32'h7FF0, 1'b0, 0);
    do_load("R9 a steady", 32'h2070, 32'h1080, 1'b1, 32'h10C0);
    do_load("R9 b steady", 32'h2074, 32'h7FE0, 1'b1, 32'h7FD0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] addrs [4] = '{32'h400, 32'h440, 32'h480, 32'h4C0};
    logic        exp_v [7] = '{0, 0, 0, 0, 1, 1, 0};
    logic [31:0] exp_a [7] = '{0, 0, 0, 0, 32'h4C0, 32'h500, 0};
    for (int c = 0; c < 7; c++) begin
      @(negedge clk_i);
      if (c >= 2) begin
        check($sformatf("R8 b2b pf_valid cycle %0d", c), {31'd0, pf_valid_o}, {31'd0, exp_v[c]});
        if (exp_v[c]) check($sformatf("R8 b2b pf_addr cycle %0d", c), pf_addr_o, exp_a[c]);
      end
      if (c < 4) begin
        ld_valid_i = 1'b1; ld_pc_i = 32'h2080; ld_addr_i = addrs[c];
      end else ld_valid_i = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    t_train();
    t_zero_step();
    t_steady_break();
    t_nopred();
    t_negative();
    t_wrap();
    t_conflict();
    t_interleave();
    t_back_to_back();
    repeat (4) @(negedge clk_i);
    check("R8 idle after traffic", {31'd0, pf_valid_o}, 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule